// File: doc/BRIEF.md
# Address Translation Cache with Table Walker

This block turns virtual addresses into physical addresses for a core's fetch, load and store paths. It holds a small, fully associative set of recent translations. A request carries a virtual address and an access kind. The block answers with either a physical address or a fault code. The page offset passes through unchanged. The virtual page number is replaced by the physical page number from a matching entry, after the entry's permission bits have been checked against the access kind.

When no entry matches, the block computes the address of the page-table word from a base input and the virtual page number. It reads that word through a single request/acknowledge memory port. A present word is installed and the lookup is retried. An absent word produces a page fault and nothing is installed. Each entry carries a modified flag that stores set. When a modified entry is chosen as victim, its flag is written back to its page-table word before the new word is read. A flush input drops every cached translation at once and writes nothing back.

Top module: `pt_xlat`

## Requirements
- R1: A request whose page is cached and permitted returns `rsp_fault` = 0 and `rsp_paddr` = {physical page number, vaddr[11:0]}, using no memory access.
- R2: On a miss the block reads the word at `pt_base + 4*vpn`, where vpn = vaddr[31:12]. If bit 31 of that word is set, its low 20 bits are installed as the physical page number, and a later request to the same page makes no memory read.
- R3: If the fetched word has bit 31 clear, the response carries `rsp_fault` = 1 and `rsp_paddr` = 0, and nothing is installed, so a repeat of the request reads memory again.
- R4: The access kind 0 (fetch) needs word bit 27, kind 1 (load) needs bit 29 and kind 2 (store) needs bit 28. A missing permission gives `rsp_fault` = 2 and `rsp_paddr` = 0.
- R5: A permitted store that hits marks its entry modified. When that entry is later evicted, the block writes its page-table word, with bit 31 and bit 30 set, the permission bits in 29..27 and the page number in 19..0, to the same address, and does this before the refill read.
- R6: Evicting an entry that is not modified causes no memory write.
- R7: Empty entries are filled first, lowest index first. Once all 8 are in use, victims are taken in rotating order starting at entry 0.
- R8: `flush` empties every entry in the cycle it is high and writes nothing back. A flush that coincides with a store hit still lets that store's response complete normally.
- R9: `req_ready` is low from the cycle after a request is accepted until its response. `rsp_valid` is a single-cycle pulse, and memory requests hold their address and direction until `mem_ack`.
- R10: After reset `req_ready` is high, and `rsp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Drop all cached translations |
| pt_base | input | 32 | Byte address of the page table |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 permission fault |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Page-table word address |
| mem_wdata | output | 32 | Word written back |
| mem_ack | input | 1 | Memory completes the pending access |
| mem_rdata | input | 32 | Word read, valid with mem_ack |

## Verification
A flush and a store hit can fall in the same cycle. The store would mark its entry modified while the flush empties the array. The bench raises `flush` exactly in the lookup cycle of a store that hits. It then expects the normal store response, and it expects a later access to that page to walk again with no write-back, because the flushed entry is no longer valid and an empty slot is refilled. The scoreboard compares each response against a page-table model, and it compares memory read and write counts, write addresses and write data against the eviction order the requirements fix.

// File: rtl/pt_xlat_pkg.sv
package pt_xlat_pkg;
   typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;
   typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_PAGE = 2'd1, FLT_PROT = 2'd2} flt_e;
   typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WB, S_RD} walk_st_e;
   localparam int PTE_W   = 32;
   localparam int PTE_V   = 31;
   localparam int PTE_D   = 30;
   localparam int PTE_R   = 29;
   localparam int PTE_WR  = 28;
   localparam int PTE_X   = 27;
   typedef struct packed {
      logic r;
      logic w;
      logic x;
   } perm_t;
endpackage

// File: rtl/pt_xlat_perm.sv
module pt_xlat_perm
   import pt_xlat_pkg::*;
(
   input  logic [1:0] kind,
   input  perm_t      perm,
   output logic       allow
);
   always_comb begin
      case (acc_e'(kind))
         ACC_FETCH: allow = perm.x;
         ACC_LOAD:  allow = perm.r;
         ACC_STORE: allow = perm.w;
         default:   allow = 1'b0;
      endcase
   end
endmodule

// File: rtl/pt_xlat_cam.sv
module pt_xlat_cam
   import pt_xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] look_vpn,
   input  logic             set_dirty,
   input  logic             clr_dirty,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  perm_t            fill_perm,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   output perm_t            hit_perm,
   output logic [IDX_W-1:0] victim_idx,
   output logic             victim_wb,
   output logic [VPN_W-1:0] victim_vpn,
   output logic [PPN_W-1:0] victim_ppn,
   output perm_t            victim_perm
);
   logic [ENTRIES-1:0] valid_q, dirty_q, match;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   perm_t              perm_q [ENTRIES];
   logic [IDX_W-1:0]   rr_q, hit_idx, free_idx;
   logic               has_free;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (vpn_q[g] == look_vpn);
   end

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      has_free = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) hit_idx = IDX_W'(i);
      end
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_q[i]) begin
            free_idx = IDX_W'(i);
            has_free = 1'b1;
         end
      end
   end

   assign hit         = |match;
   assign hit_ppn     = ppn_q[hit_idx];
   assign hit_perm    = perm_q[hit_idx];
   assign victim_idx  = has_free ? free_idx : rr_q;
   assign victim_wb   = valid_q[victim_idx] && dirty_q[victim_idx];
   assign victim_vpn  = vpn_q[victim_idx];
   assign victim_ppn  = ppn_q[victim_idx];
   assign victim_perm = perm_q[victim_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         rr_q    <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            vpn_q[i]  <= '0;
            ppn_q[i]  <= '0;
            perm_q[i] <= '0;
         end
      end else begin
         if (set_dirty) dirty_q[hit_idx] <= 1'b1;
         if (clr_dirty) dirty_q[clr_idx] <= 1'b0;
         if (flush) begin
            valid_q <= '0;
         end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
            dirty_q[fill_idx] <= 1'b0;
            vpn_q[fill_idx]   <= fill_vpn;
            ppn_q[fill_idx]   <= fill_ppn;
            perm_q[fill_idx]  <= fill_perm;
            if (&valid_q)
               rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
         end
      end
   end

   // R8: a flush leaves no valid entry behind
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));
   // R7: a page never sits in two entries
   a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   // R5: a fresh entry starts unmodified
   a_r5_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush) |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]));
endmodule

// File: rtl/pt_xlat.sv
module pt_xlat
   import pt_xlat_pkg::*;
#(
   parameter int ENTRIES   = 8,
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic [PA_W-1:0] pt_base,
   input  logic            req_valid,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [1:0]      req_kind,
   output logic            req_ready,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_paddr,
   output logic [1:0]      rsp_fault,
   output logic            mem_req,
   output logic            mem_we,
   output logic [PA_W-1:0] mem_addr,
   output logic [PTE_W-1:0] mem_wdata,
   input  logic            mem_ack,
   input  logic [PTE_W-1:0] mem_rdata
);
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PPN_W = PA_W - PAGE_BITS;
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int PAD_W = PTE_X - PPN_W;
   localparam int AHI_W = PA_W - VPN_W - 2;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("pt_xlat: ENTRIES must be at least 2");
   end
   if (PPN_W > PTE_X - 1) begin : g_bad_ppn
      $error("pt_xlat: page number does not fit the table word");
   end
   if (AHI_W < 0) begin : g_bad_addr
      $error("pt_xlat: table address narrower than scaled page number");
   end

   walk_st_e         st_q;
   logic [VA_W-1:0]  va_q;
   logic [1:0]       kind_q;
   logic [IDX_W-1:0] vic_q;
   logic [PA_W-1:0]  wb_addr_q;
   logic [PTE_W-1:0] wb_data_q;
   logic             rsp_valid_q;
   logic [PA_W-1:0]  rsp_paddr_q;
   logic [1:0]       rsp_fault_q;

   logic             hit, allow, victim_wb;
   logic [PPN_W-1:0] hit_ppn, victim_ppn;
   perm_t            hit_perm, victim_perm, fill_perm;
   logic [IDX_W-1:0] victim_idx;
   logic [VPN_W-1:0] victim_vpn, vpn_cur;
   logic             set_dirty, clr_dirty, fill_en;

   function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] base,
                                                input logic [VPN_W-1:0] vpn);
      return base + {{AHI_W{1'b0}}, vpn, 2'b00};
   endfunction

   assign vpn_cur   = va_q[VA_W-1:PAGE_BITS];
   assign fill_perm = '{r: mem_rdata[PTE_R], w: mem_rdata[PTE_WR], x: mem_rdata[PTE_X]};
   assign set_dirty = (st_q == S_LOOK) && hit && allow && (acc_e'(kind_q) == ACC_STORE);
   assign clr_dirty = (st_q == S_WB) && mem_ack;
   assign fill_en   = (st_q == S_RD) && mem_ack && mem_rdata[PTE_V];

   pt_xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
      .clk(clk), .rst_n(rst_n), .flush(flush), .look_vpn(vpn_cur),
      .set_dirty(set_dirty), .clr_dirty(clr_dirty), .clr_idx(vic_q),
      .fill_en(fill_en), .fill_idx(vic_q), .fill_vpn(vpn_cur),
      .fill_ppn(mem_rdata[PPN_W-1:0]), .fill_perm(fill_perm),
      .hit(hit), .hit_ppn(hit_ppn), .hit_perm(hit_perm),
      .victim_idx(victim_idx), .victim_wb(victim_wb), .victim_vpn(victim_vpn),
      .victim_ppn(victim_ppn), .victim_perm(victim_perm)
   );

   pt_xlat_perm u_perm (.kind(kind_q), .perm(hit_perm), .allow(allow));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         va_q        <= '0;
         kind_q      <= '0;
         vic_q       <= '0;
         wb_addr_q   <= '0;
         wb_data_q   <= '0;
         rsp_valid_q <= 1'b0;
         rsp_paddr_q <= '0;
         rsp_fault_q <= FLT_NONE;
      end else begin
         rsp_valid_q <= 1'b0;
         case (st_q)
            S_IDLE: if (req_valid) begin
               va_q   <= req_vaddr;
               kind_q <= req_kind;
               st_q   <= S_LOOK;
            end
            S_LOOK: if (hit) begin
               rsp_valid_q <= 1'b1;
               rsp_paddr_q <= allow ? {hit_ppn, va_q[PAGE_BITS-1:0]} : '0;
               rsp_fault_q <= allow ? FLT_NONE : FLT_PROT;
               st_q        <= S_IDLE;
            end else begin
               vic_q     <= victim_idx;
               wb_addr_q <= pte_addr(pt_base, victim_vpn);
               wb_data_q <= {1'b1, 1'b1, victim_perm.r, victim_perm.w, victim_perm.x,
                             {PAD_W{1'b0}}, victim_ppn};
               st_q      <= victim_wb ? S_WB : S_RD;
            end
            S_WB: if (mem_ack) st_q <= S_RD;
            S_RD: if (mem_ack) begin
               if (mem_rdata[PTE_V]) begin
                  st_q <= S_LOOK;
               end else begin
                  rsp_valid_q <= 1'b1;
                  rsp_paddr_q <= '0;
                  rsp_fault_q <= FLT_PAGE;
                  st_q        <= S_IDLE;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == S_IDLE);
   assign rsp_valid = rsp_valid_q;
   assign rsp_paddr = rsp_paddr_q;
   assign rsp_fault = rsp_fault_q;
   assign mem_req   = (st_q == S_WB) || (st_q == S_RD);
   assign mem_we    = (st_q == S_WB);
   assign mem_addr  = (st_q == S_WB) ? wb_addr_q : pte_addr(pt_base, vpn_cur);
   assign mem_wdata = wb_data_q;

   // R9: an accepted request makes the block busy
   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R9: the result strobe lasts one cycle
   a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R9: a pending memory access is held until acknowledged
   a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   // R5: a completed write-back is followed by the refill read
   a_r5_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
   // R3: a faulting response carries no address
   a_r3_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
endmodule

// File: tb/pt_xlat_test.sv
`timescale 1ns/1ps
module pt_xlat_test;
   localparam logic [31:0] PTBR = 32'h0004_0000;

   logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_ready, rsp_valid, mem_req, mem_we;
   logic [31:0] rsp_paddr, mem_addr, mem_wdata;
   logic [1:0]  rsp_fault;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #2 clk = ~clk;

   pt_xlat uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(PTBR),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );

   int tests = 0, fails = 0, cyc = 0;
   logic [31:0] pt [64];
   int rd_cnt = 0, wr_cnt = 0, mcnt = 0;
   logic [31:0] last_raddr = '0, last_waddr = '0, last_wdata = '0;
   logic prev_op_w = 1'b0, last_op_w = 1'b0;

   logic [31:0] exp_pa [$];
   logic [1:0]  exp_ft [$];
   string       exp_tag [$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // memory model: acknowledges after two waiting cycles
   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         if (mcnt == 2) begin
            mcnt <= 0;
            mem_ack <= 1'b1;
            mem_rdata <= pt[(mem_addr - PTBR) >> 2];
            prev_op_w <= last_op_w;
            last_op_w <= mem_we;
            if (mem_we) begin
               pt[(mem_addr - PTBR) >> 2] <= mem_wdata;
               wr_cnt <= wr_cnt + 1;
               last_waddr <= mem_addr;
               last_wdata <= mem_wdata;
            end else begin
               rd_cnt <= rd_cnt + 1;
               last_raddr <= mem_addr;
            end
         end else begin
            mcnt <= mcnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // monitor: compares each result with the oldest expected item
   always @(negedge clk) begin
      if (rsp_valid) begin
         if (exp_pa.size() == 0) begin
            chk(1'b0, "R9", "unexpected response", rsp_paddr, 32'h0);
         end else begin
            logic [31:0] ep;
            logic [1:0]  ef;
            string       et;
            ep = exp_pa.pop_front();
            ef = exp_ft.pop_front();
            et = exp_tag.pop_front();
            chk(rsp_paddr == ep, et, "paddr", rsp_paddr, ep);
            chk(rsp_fault == ef, et, "fault", {30'd0, rsp_fault}, {30'd0, ef});
         end
      end
   end

   task automatic expect_of(input logic [31:0] va, input logic [1:0] kind);
      logic [31:0] w;
      logic ok;
      w = pt[va[17:12]];
      ok = (kind == 2'd0) ? w[27] : (kind == 2'd1) ? w[29] : w[28];
      if (!w[31]) begin
         exp_pa.push_back(32'h0); exp_ft.push_back(2'd1); exp_tag.push_back("R3");
      end else if (!ok) begin
         exp_pa.push_back(32'h0); exp_ft.push_back(2'd2); exp_tag.push_back("R4");
      end else begin
         exp_pa.push_back({w[19:0], va[11:0]}); exp_ft.push_back(2'd0); exp_tag.push_back("R1");
      end
   endtask

   // driver: one request, optional flush in its lookup cycle
   task automatic xlat(input logic [31:0] va, input logic [1:0] kind, input bit with_flush);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      expect_of(va, kind);
      req_vaddr = va;
      req_kind  = kind;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      flush = with_flush;
      @(negedge clk);
      flush = 1'b0;
      while (exp_pa.size() != 0) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         fails++; tests++;
         $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int r0, w0;
      for (int i = 0; i < 64; i++) pt[i] = {1'b1, 1'b0, 3'b111, 7'd0, 20'h100 + 20'(i)};
      pt[5] = 32'h0;
      pt[6] = {1'b1, 1'b0, 3'b100, 7'd0, 20'h106};
      pt[7] = {1'b1, 1'b0, 3'b001, 7'd0, 20'h107};
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R10", "ready in reset", {31'd0, req_ready}, 32'd1);
      chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      chk(mem_req == 1'b0, "R10", "mem_req in reset", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;

      // R3: absent page, not installed
      xlat(32'h0000_5abc, 2'd1, 1'b0);
      chk(rd_cnt == 1, "R3", "first walk reads", rd_cnt, 1);
      xlat(32'h0000_5abc, 2'd1, 1'b0);
      chk(rd_cnt == 2, "R3", "repeat walks again", rd_cnt, 2);

      // R2 / R9: first walk and address of the table word
      @(negedge clk);
      req_vaddr = 32'h0000_A123; req_kind = 2'd1; req_valid = 1'b1;
      expect_of(32'h0000_A123, 2'd1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9", "busy after accept", {31'd0, req_ready}, 32'd0);
      while (exp_pa.size() != 0) @(negedge clk);
      chk(last_raddr == PTBR + 32'd40, "R2", "table word address", last_raddr, PTBR + 32'd40);
      r0 = rd_cnt;
      xlat(32'h0000_AFFF, 2'd1, 1'b0);
      xlat(32'h0000_A000, 2'd0, 1'b0);
      xlat(32'h0000_A010, 2'd2, 1'b0);
      chk(rd_cnt == r0, "R2", "installed page needs no read", rd_cnt, r0);

      // fill entries 1..7 with pages 11..17
      for (int p = 11; p <= 17; p++) xlat({12'd0, 8'(p), 12'h040}, 2'd1, 1'b0);
      chk(wr_cnt == 0, "R6", "no write while empty slots remain", wr_cnt, 0);

      // R5: page 18 evicts entry 0 (page 10, modified)
      xlat(32'h0001_2008, 2'd1, 1'b0);
      chk(wr_cnt == 1, "R5", "one write-back", wr_cnt, 1);
      chk(last_waddr == PTBR + 32'd40, "R5", "write-back address", last_waddr, PTBR + 32'd40);
      chk(last_wdata == {1'b1, 1'b1, 3'b111, 7'd0, 20'h10A}, "R5", "write-back word",
          last_wdata, {1'b1, 1'b1, 3'b111, 7'd0, 20'h10A});
      chk(prev_op_w && !last_op_w, "R5", "write before read", {prev_op_w, last_op_w}, 2'b10);

      // R6 / R7: page 19 evicts entry 1 (page 11, clean)
      xlat(32'h0001_3000, 2'd1, 1'b0);
      chk(wr_cnt == 1, "R6", "clean victim not written", wr_cnt, 1);
      r0 = rd_cnt;
      xlat(32'h0000_C004, 2'd1, 1'b0);
      chk(rd_cnt == r0, "R7", "entry 2 still resident", rd_cnt, r0);
      xlat(32'h0000_B004, 2'd1, 1'b0);
      chk(rd_cnt == r0 + 1, "R7", "entry 1 was the rotating victim", rd_cnt, r0 + 1);

      // R8: flush coincides with a store hit on page 13
      w0 = wr_cnt; r0 = rd_cnt;
      xlat(32'h0000_D0F0, 2'd2, 1'b1);
      chk(rd_cnt == r0, "R8", "store hit served without walk", rd_cnt, r0);
      xlat(32'h0000_D0F0, 2'd1, 1'b0);
      chk(rd_cnt == r0 + 1, "R8", "flushed page walks again", rd_cnt, r0 + 1);
      chk(wr_cnt == w0, "R8", "no write-back after flush", wr_cnt, w0);

      // R4: permission checks
      xlat(32'h0000_6100, 2'd2, 1'b0);
      xlat(32'h0000_6100, 2'd1, 1'b0);
      xlat(32'h0000_7200, 2'd0, 1'b0);
      xlat(32'h0000_7200, 2'd1, 1'b0);
      xlat(32'h0000_7200, 2'd2, 1'b0);

      repeat (4) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule